// File: doc/BRIEF.md
# Steerable Prioritized Interrupt Controller

The block gathers level-sensitive interrupt requests from on-chip peripherals. Each request goes through a two-flop synchroniser into a pending register. The pending register always shows the raw request state. An enable mask selects which sources take part. A steering bit then sends each enabled source to one of two groups: fast or normal. Each group has its own read-only source register and its own interrupt output.

Each source carries a 2-bit priority level. When vector generation is on, each group independently resolves the single best active source. That source is reported as an index with a valid flag. If several sources share the best level, the higher bit index wins. All configuration goes through a small register read/write port. Writes are synchronous and reads are combinational.

Top module: `irq_steer_prio`

## Requirements
- R1: Each bit of `irq_i` reaches the pending register (address 4) after exactly two rising clock edges. The pending register shows the request whether or not the source is enabled.
- R2: A source appears in a group source register only while its enable bit (address 0, bit i, 1 = enabled) is set and its pending bit is set.
- R3: Steering bit i (address 1) selects the group for source i: 1 = fast, 0 = normal. The fast source register (address 5) and the normal source register (address 6) are the pending bits that are enabled and steered to that group. A source never appears in both.
- R4: `fast_irq` is high exactly when the fast source register is non-zero. `norm_irq` is high exactly when the normal source register is non-zero.
- R5: The priority register (address 2) holds the level of source i in bits [2i+1:2i]. Value 00 is the highest level and 11 the lowest. Each group's vector names an active source of that group with the numerically lowest level.
- R6: When several active sources in a group share the best level, the source with the highest index is chosen.
- R7: The vector-valid flag of a group is high only when vector generation is enabled (address 3, bit 0) and the group has an active source. Whenever the flag is low, the vector index is 0.
- R8: After reset, enable, steering, priority and control all read 0. A register write becomes visible on the read port only after the next rising clock edge.
- R9: Writes to the read-only addresses 4 to 7 change no register. Reads of address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NSRC | Level interrupt requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 2*NSRC | Write data |
| reg_rdata | output | 2*NSRC | Combinational read data |
| fast_irq | output | 1 | Fast group interrupt |
| norm_irq | output | 1 | Normal group interrupt |
| fast_vld | output | 1 | Fast vector valid |
| fast_vec | output | clog2(NSRC) | Fast vector index |
| norm_vld | output | 1 | Normal vector valid |
| norm_vec | output | clog2(NSRC) | Normal vector index |

## Verification
The table drives the two groups together under several conditions:
- an all-normal setup and an all-fast setup, to separate steering from masking;
- a split setup with mixed levels, where the two groups must resolve differently at the same time;
- a partial mask that hides the better-level sources of one group;
- equal levels everywhere, to expose the tie-break direction;
- no requests at all, and every request masked, where the vectors must read as zero.

Directed tests add the following:
- the two-edge synchroniser latency;
- write visibility one edge late;
- ignored writes to read-only addresses;
- vector generation off while the interrupt outputs stay high.

// File: rtl/irq_steer_prio.sv
module irq_steer_prio #(
  parameter int NSRC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_i,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [2*NSRC-1:0]     reg_wdata,
  output logic [2*NSRC-1:0]     reg_rdata,
  output logic                  fast_irq,
  output logic                  norm_irq,
  output logic                  fast_vld,
  output logic [(NSRC>1?$clog2(NSRC):1)-1:0] fast_vec,
  output logic                  norm_vld,
  output logic [(NSRC>1?$clog2(NSRC):1)-1:0] norm_vec
);
  localparam int DW = 2 * NSRC;
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int PADW = DW - NSRC;

  logic [NSRC-1:0] sync1, pend, en_mask, steer;
  logic [DW-1:0]   prio;
  logic            vec_en;
  logic [NSRC-1:0] fsrc, nsrc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      pend  <= '0;
    end else begin
      sync1 <= irq_i;
      pend  <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask <= '0;
      steer   <= '0;
      prio    <= '0;
      vec_en  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: en_mask <= reg_wdata[NSRC-1:0];
        3'd1: steer   <= reg_wdata[NSRC-1:0];
        3'd2: prio    <= reg_wdata;
        3'd3: vec_en  <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assign fsrc = pend & en_mask & steer;
  assign nsrc = pend & en_mask & ~steer;
  assign fast_irq = |fsrc;
  assign norm_irq = |nsrc;

  function automatic logic [IW:0] pick(input logic [NSRC-1:0] act, input logic [DW-1:0] pr);
    logic [1:0]    best;
    logic          found;
    logic [IW-1:0] idx;
    best = 2'b11;
    found = 1'b0;
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && (!found || pr[2*i +: 2] <= best)) begin
        found = 1'b1;
        best = pr[2*i +: 2];
        idx = IW'(i);
      end
    end
    return {found, idx};
  endfunction

  assign {fast_vld, fast_vec} = vec_en ? pick(fsrc, prio) : '0;
  assign {norm_vld, norm_vec} = vec_en ? pick(nsrc, prio) : '0;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {{PADW{1'b0}}, en_mask};
      3'd1:    reg_rdata = {{PADW{1'b0}}, steer};
      3'd2:    reg_rdata = prio;
      3'd3:    reg_rdata = {{(DW-1){1'b0}}, vec_en};
      3'd4:    reg_rdata = {{PADW{1'b0}}, pend};
      3'd5:    reg_rdata = {{PADW{1'b0}}, fsrc};
      3'd6:    reg_rdata = {{PADW{1'b0}}, nsrc};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module irq_steer_prio_chk #(
  parameter int NSRC = 4,
  parameter int IW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_i,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] en_mask,
  input logic [NSRC-1:0] fsrc,
  input logic [NSRC-1:0] nsrc,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [2*NSRC-1:0] reg_wdata,
  input logic            fast_irq,
  input logic            norm_irq,
  input logic            fast_vld,
  input logic [IW-1:0]   fast_vec,
  input logic            norm_vld,
  input logic [IW-1:0]   norm_vec
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_pend_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> pend == $past(irq_i, 2));

  p_src_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsrc | nsrc) & ~(pend & en_mask)) == '0);

  p_groups_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsrc & nsrc) == '0);

  p_fast_vec_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_vld |-> (fast_irq && fsrc[fast_vec]));

  p_norm_vec_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    norm_vld |-> (norm_irq && nsrc[norm_vec]));

  p_vec_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_vld |-> fast_vec == '0) and (!norm_vld |-> norm_vec == '0));

  p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0) |=> en_mask == $past(reg_wdata[NSRC-1:0]));
endmodule

bind irq_steer_prio irq_steer_prio_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .pend(pend), .en_mask(en_mask),
  .fsrc(fsrc), .nsrc(nsrc), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fast_irq(fast_irq), .norm_irq(norm_irq),
  .fast_vld(fast_vld), .fast_vec(fast_vec), .norm_vld(norm_vld), .norm_vec(norm_vec)
);

// File: tb/irq_steer_prio_test.sv
module irq_steer_prio_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_i = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       fast_irq, norm_irq, fast_vld, norm_vld;
  logic [1:0] fast_vec, norm_vec;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_steer_prio #(.NSRC(4)) uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fast_irq(fast_irq), .norm_irq(norm_irq),
    .fast_vld(fast_vld), .fast_vec(fast_vec), .norm_vld(norm_vld), .norm_vec(norm_vec)
  );

  typedef struct packed {
    logic [3:0] mask, steer;
    logic [7:0] prio;
    logic [3:0] irq, fsrc, nsrc;
    logic fv; logic [1:0] fvec;
    logic nv; logic [1:0] nvec;
  } row_t;

  localparam row_t TBL [8] = '{
    '{4'hF, 4'h0, 8'h00, 4'hA, 4'h0, 4'hA, 1'b0, 2'd0, 1'b1, 2'd3},
    '{4'hF, 4'hF, 8'h00, 4'h6, 4'h6, 4'h0, 1'b1, 2'd2, 1'b0, 2'd0},
    '{4'hF, 4'h5, 8'h9C, 4'hF, 4'h5, 4'hA, 1'b1, 2'd0, 1'b1, 2'd3},
    '{4'hF, 4'h5, 8'h9C, 4'hE, 4'h4, 4'hA, 1'b1, 2'd2, 1'b1, 2'd3},
    '{4'h3, 4'h0, 8'h9C, 4'hF, 4'h0, 4'h3, 1'b0, 2'd0, 1'b1, 2'd0},
    '{4'hF, 4'h0, 8'hFF, 4'h3, 4'h0, 4'h3, 1'b0, 2'd0, 1'b1, 2'd1},
    '{4'hF, 4'h0, 8'h9C, 4'h0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0},
    '{4'h0, 4'h0, 8'h9C, 4'hF, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); chk("R8 reset reg", d, 0);
    end
    irq_i = 4'hF; settle();
    chk("R8 reset outputs masked", {fast_irq, norm_irq, fast_vld, norm_vld}, 0);

    // R1 synchroniser latency, independent of mask
    irq_i = 4'h0; settle();
    @(negedge clk); irq_i = 4'h9;
    @(negedge clk); reg_addr = 3'd4; #0.5 chk("R1 pending after one edge", reg_rdata, 0);
    @(negedge clk); #0.5 chk("R1 pending after two edges", reg_rdata, 9);

    // R8 write visible only after the edge
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h0F;
    #0.5 chk("R8 write before edge", reg_rdata, 0);
    @(negedge clk); reg_we = 1'b0; #0.5 chk("R8 write after edge", reg_rdata, 8'h0F);

    // R9 read-only addresses ignore writes
    wr(3'd4, 8'h00); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd4, d); chk("R9 pending unchanged", d, 9);
    rd(3'd0, d); chk("R9 mask unchanged", d, 8'h0F);
    rd(3'd1, d); chk("R9 steer unchanged", d, 0);
    rd(3'd7, d); chk("R9 addr7 reads zero", d, 0);

    // R7 vector generation disabled while outputs assert
    chk("R7 norm_irq still high", norm_irq, 1);
    chk("R7 vld and vec zero when disabled", {fast_vld, fast_vec, norm_vld, norm_vec}, 0);

    wr(3'd3, 8'h01);
    rd(3'd3, d); chk("R8 ctrl readback", d, 1);

    foreach (TBL[i]) begin
      wr(3'd0, {4'h0, TBL[i].mask});
      wr(3'd1, {4'h0, TBL[i].steer});
      wr(3'd2, TBL[i].prio);
      irq_i = TBL[i].irq;
      settle();
      rd(3'd4, d); chk($sformatf("R1 row%0d pending", i), d, TBL[i].irq);
      rd(3'd5, d); chk($sformatf("R2 R3 row%0d fast src", i), d, TBL[i].fsrc);
      rd(3'd6, d); chk($sformatf("R2 R3 row%0d norm src", i), d, TBL[i].nsrc);
      chk($sformatf("R4 row%0d outputs", i), {fast_irq, norm_irq}, {TBL[i].fsrc != 0, TBL[i].nsrc != 0});
      chk($sformatf("R5 R6 R7 row%0d fast vector", i), {fast_vld, fast_vec}, {TBL[i].fv, TBL[i].fvec});
      chk($sformatf("R5 R6 R7 row%0d norm vector", i), {norm_vld, norm_vec}, {TBL[i].nv, TBL[i].nvec});
    end

    // R6 tie in fast group: all level 01, sources 0 and 1 fast
    wr(3'd0, 8'h0F); wr(3'd1, 8'h03); wr(3'd2, 8'h55);
    irq_i = 4'h3; settle();
    chk("R6 fast tie highest index", {fast_vld, fast_vec}, {1'b1, 2'd1});

    // R5 level ordering: src3 level 01 beats src0..2 level 10
    wr(3'd1, 8'h00); wr(3'd2, 8'h6A);
    irq_i = 4'hF; settle();
    chk("R5 better level wins over index", {norm_vld, norm_vec}, {1'b1, 2'd3});
    wr(3'd2, 8'hA9);
    settle();
    chk("R5 level 01 at src0 wins", {norm_vld, norm_vec}, {1'b1, 2'd0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule